// File: doc/BRIEF.md
# Per-Channel Latch-and-Clear Statistics Counters

This block keeps the condition counters for a multi-port cell-based physical-layer device. Each channel has four saturating event counters of unequal width. One counts invalid line symbols. One counts transmitted cells. One counts good received cells. One counts received cells whose header checksum failed. The transmit and receive paths deliver single-cycle pulses. A received-cell pulse comes with two qualifiers, "idle" and "checksum bad", and the block sorts each received cell into the right counter from those qualifiers.

Software reads a counter in two steps. First it writes a one-hot value to the channel's select register. That single write copies the chosen count into a 16-bit holding pair and clears the live counter in the same cycle. Software then reads the low and high bytes of the holding pair. The three channels repeat at a fixed address stride and are fully independent of each other.

Top module: `stat_bank_top`

## Requirements
- R1: The symbol-error counter is 8 bits wide and adds one for each cycle in which that channel's `sym_err_pulse` bit is high.
- R2: The transmit-cell counter is 16 bits wide and adds one for each `tx_cell_pulse`.
- R3: The receive-cell counter is 16 bits wide and adds one for an `rx_cell_pulse` only when neither `rx_idle` nor `rx_hec_bad` is high in that cycle.
- R4: The checksum-error counter is 5 bits wide and adds one for each `rx_cell_pulse` that has `rx_hec_bad` high, whatever the value of `rx_idle`.
- R5: A write to channel offset 0x6 with exactly one of bits 3..0 set, and bits 7..4 clear, does two things in the same cycle. It loads the holding pair with the selected count and clears that counter. The select bits are: bit 0 symbol errors, bit 1 transmit cells, bit 2 receive cells, bit 3 checksum errors. Offset 0x4 then reads the low byte and offset 0x5 reads the high byte.
- R6: A select write whose value is not one of the four valid one-hot codes is ignored. The holding pair does not change and no counter is cleared.
- R7: When an event arrives in the same cycle as the clear of its counter, the latched value leaves that event out and the counter restarts at one.
- R8: Each counter stops at its all-ones value instead of wrapping around.
- R9: The narrow counters are zero-extended into the holding pair, so the high byte reads 0 for the symbol and checksum counters.
- R10: Channel c sits at base address c×0x10. The channels do not affect each other. Any address that is not a low or high byte of an existing channel reads 0, and this includes the select offset.
- R11: After reset every counter and every holding pair is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_err_pulse | input | NUM_CH | Invalid line symbol seen, one bit per channel |
| tx_cell_pulse | input | NUM_CH | Cell transmitted, per channel |
| rx_cell_pulse | input | NUM_CH | Cell received, per channel |
| rx_idle | input | NUM_CH | Qualifier: the received cell is idle |
| rx_hec_bad | input | NUM_CH | Qualifier: the received cell failed its header checksum |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from the address) |

## Verification
The bench builds the block with its default parameters: three channels, an 8-bit address, a 0x10 stride, and counter widths of 8, 16, 16 and 5. With these settings a short burst of pulses drives both the 5-bit and the 8-bit counters to saturation. A 16-bit counter crosses into its high byte after a few hundred pulses, which confirms that the byte split is correct. Reaching saturation on the 16-bit counters would take about 65 thousand pulses, so it is only checked through the shared counter module.

// File: rtl/stat_pkg.sv
package stat_pkg;

    localparam int NUM_KINDS = 4;
    localparam int HOLD_W    = 16;

    // channel-relative register offsets
    localparam int OFF_LO  = 4;
    localparam int OFF_HI  = 5;
    localparam int OFF_SEL = 6;

    typedef enum logic [1:0] {
        K_SYM = 2'd0,
        K_TX  = 2'd1,
        K_RX  = 2'd2,
        K_HEC = 2'd3
    } kind_e;

    typedef struct packed {
        logic hec;
        logic rx;
        logic tx;
        logic sym;
    } ev_s;

    function automatic int kind_width(int k);
        case (k)
            int'(K_SYM): return 8;
            int'(K_TX):  return 16;
            int'(K_RX):  return 16;
            default:     return 5;
        endcase
    endfunction

    function automatic logic sel_valid(logic [7:0] v);
        logic [3:0] lo;
        lo = v[3:0];
        return (v[7:4] == 4'd0) && (lo != 4'd0) && ((lo & (lo - 4'd1)) == 4'd0);
    endfunction

endpackage

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         clr,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            count <= '0;
        else if (clr)
            count <= inc ? ONE : '0;
        else if (inc && count != MAXV)
            count <= count + ONE;
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (count == MAXV && !clr) |=> count == MAXV);

    // R7
    clear_restart_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == (W'($past(inc))));

    // R1
    no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
        !clr |=> count >= $past(count));

endmodule

// File: rtl/chan_stats.sv
module chan_stats
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_ev,
    input  logic              tx_ev,
    input  logic              rx_ev,
    input  logic              rx_idle,
    input  logic              rx_hec_bad,
    input  logic              sel_wr,
    input  logic [7:0]        sel_data,
    output logic [HOLD_W-1:0] hold
);
    ev_s                                ev;
    logic                               wr_ok;
    logic [NUM_KINDS-1:0]               clr;
    logic [NUM_KINDS-1:0][HOLD_W-1:0]   ext;
    logic [HOLD_W-1:0]                  pick;

    always_comb begin
        ev.sym = sym_ev;
        ev.tx  = tx_ev;
        ev.rx  = rx_ev & ~rx_idle & ~rx_hec_bad;
        ev.hec = rx_ev & rx_hec_bad;
    end

    assign wr_ok = sel_wr && sel_valid(sel_data);
    assign clr   = wr_ok ? sel_data[NUM_KINDS-1:0] : '0;

    generate
        for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
            localparam int W = kind_width(k);
            logic [W-1:0] c;
            sat_counter #(.W(W)) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .inc   (ev[k]),
                .clr   (clr[k]),
                .count (c)
            );
            assign ext[k] = HOLD_W'(c);
        end
    endgenerate

    always_comb begin
        pick = '0;
        for (int k = 0; k < NUM_KINDS; k++)
            if (sel_data[k]) pick = ext[k];
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold <= '0;
        else if (wr_ok)
            hold <= pick;
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(sel_wr && sel_valid(sel_data)) |=> $stable(hold));

    // R9
    narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && (sel_data[int'(K_HEC)] || sel_data[int'(K_SYM)])) |=> hold[15:8] == 8'd0);

endmodule

// File: rtl/stat_addr_map.sv
module stat_addr_map
    import stat_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int ADDR_W      = 8,
    parameter int STRIDE_LOG2 = 4
) (
    input  logic                          wr,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_CH-1:0][HOLD_W-1:0] hold,
    output logic [NUM_CH-1:0]             sel_wr,
    output logic [7:0]                    rdata
);
    localparam int CH_W = ADDR_W - STRIDE_LOG2;

    logic [CH_W-1:0]        ch_f;
    logic [STRIDE_LOG2-1:0] off_f;

    assign ch_f  = addr[ADDR_W-1:STRIDE_LOG2];
    assign off_f = addr[STRIDE_LOG2-1:0];

    always_comb begin
        sel_wr = '0;
        rdata  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (int'(ch_f) == c) begin
                sel_wr[c] = wr && (int'(off_f) == OFF_SEL);
                if (int'(off_f) == OFF_LO) rdata = hold[c][7:0];
                if (int'(off_f) == OFF_HI) rdata = hold[c][15:8];
            end
        end
    end

    // R10
    always_comb begin
        one_select_chk: assert ($countones(sel_wr) <= 1);
    end

endmodule

// File: rtl/stat_bank_top.sv
module stat_bank_top
    import stat_pkg::*;
#(
    parameter int NUM_CH      = 3,
    parameter int ADDR_W      = 8,
    parameter int STRIDE_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] sym_err_pulse,
    input  logic [NUM_CH-1:0] tx_cell_pulse,
    input  logic [NUM_CH-1:0] rx_cell_pulse,
    input  logic [NUM_CH-1:0] rx_idle,
    input  logic [NUM_CH-1:0] rx_hec_bad,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata
);
    logic [NUM_CH-1:0][HOLD_W-1:0] hold;
    logic [NUM_CH-1:0]             sel_wr;

    stat_addr_map #(
        .NUM_CH      (NUM_CH),
        .ADDR_W      (ADDR_W),
        .STRIDE_LOG2 (STRIDE_LOG2)
    ) u_map (
        .wr     (reg_wr),
        .addr   (reg_addr),
        .hold   (hold),
        .sel_wr (sel_wr),
        .rdata  (reg_rdata)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            chan_stats u_ch (
                .clk        (clk),
                .rst        (rst),
                .sym_ev     (sym_err_pulse[c]),
                .tx_ev      (tx_cell_pulse[c]),
                .rx_ev      (rx_cell_pulse[c]),
                .rx_idle    (rx_idle[c]),
                .rx_hec_bad (rx_hec_bad[c]),
                .sel_wr     (sel_wr[c]),
                .sel_data   (reg_wdata),
                .hold       (hold[c])
            );
        end
    endgenerate

endmodule

// File: tb/tb_stat_bank_top.sv
`timescale 1ns/1ps
module tb_stat_bank_top;
    localparam int NCH = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] sym = '0, tx = '0, rx = '0, idl = '0, hb = '0;
    logic           wr = 1'b0;
    logic [7:0]     addr = '0, wdata = '0;
    logic [7:0]     rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int unsigned    mcnt [NCH][4];
    logic [15:0]    mhold [NCH];

    stat_bank_top dut (
        .clk(clk), .rst(rst),
        .sym_err_pulse(sym), .tx_cell_pulse(tx), .rx_cell_pulse(rx),
        .rx_idle(idl), .rx_hec_bad(hb),
        .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
    );

    always #10 clk = ~clk;

    function automatic int unsigned kmax(int k);
        case (k)
            0: return 255;
            3: return 31;
            default: return 65535;
        endcase
    endfunction

    function automatic bit valid_sel(logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) if (v[i]) n++;
        return (n == 1) && (v[7:4] == 0);
    endfunction

    function automatic logic [7:0] exp_read(logic [7:0] a);
        int c = int'(a[7:4]);
        if (c < NCH && a[3:0] == 4) return mhold[c][7:0];
        if (c < NCH && a[3:0] == 5) return mhold[c][15:8];
        return 8'h00;
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, expv);
        end
    endtask

    task automatic cycle(logic [NCH-1:0] s, logic [NCH-1:0] t, logic [NCH-1:0] r,
                         logic [NCH-1:0] i, logic [NCH-1:0] h,
                         logic w, logic [7:0] a, logic [7:0] d, string tag);
        bit ev;
        int ch;
        int k;
        @(negedge clk);
        sym = s; tx = t; rx = r; idl = i; hb = h; wr = w; addr = a; wdata = d;
        #1;
        check(tag, rdata, exp_read(a));
        @(posedge clk);
        for (int c = 0; c < NCH; c++) begin
            ch = int'(a[7:4]);
            k = -1;
            if (w && ch == c && a[3:0] == 6 && valid_sel(d)) begin
                for (int b = 0; b < 4; b++) if (d[b]) k = b;
                mhold[c] = 16'(mcnt[c][k]);
            end
            for (int q = 0; q < 4; q++) begin
                case (q)
                    0: ev = s[c];
                    1: ev = t[c];
                    2: ev = r[c] && !i[c] && !h[c];
                    default: ev = r[c] && h[c];
                endcase
                if (q == k) mcnt[c][q] = ev ? 1 : 0;
                else if (ev && mcnt[c][q] < kmax(q)) mcnt[c][q]++;
            end
        end
    endtask

    task automatic idle_n(int n);
        for (int j = 0; j < n; j++) cycle('0, '0, '0, '0, '0, 0, 8'h00, 8'h00, "R11");
    endtask

    task automatic pulses(int c, int q, int n, logic i, logic h);
        logic [NCH-1:0] m = NCH'(1) << c;
        for (int j = 0; j < n; j++)
            cycle(q == 0 ? m : '0, q == 1 ? m : '0, q >= 2 ? m : '0,
                  i ? m : '0, h ? m : '0, 0, 8'h00, 8'h00, "R1 R2 R3 R4");
    endtask

    task automatic grab(int c, int q, logic [15:0] expv, string tag);
        cycle('0, '0, '0, '0, '0, 1, 8'(c * 16 + 6), 8'(1 << q), tag);
        cycle('0, '0, '0, '0, '0, 0, 8'(c * 16 + 4), 8'h00, tag);
        check(tag, rdata, expv[7:0]);
        cycle('0, '0, '0, '0, '0, 0, 8'(c * 16 + 5), 8'h00, tag);
        check(tag, rdata, expv[15:8]);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        for (int c = 0; c < NCH; c++) begin
            mhold[c] = '0;
            for (int q = 0; q < 4; q++) mcnt[c][q] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R11 reset state: holding pairs and counters are zero
        for (int c = 0; c < NCH; c++) begin
            grab(c, 0, 16'h0000, "R11");
            grab(c, 3, 16'h0000, "R11");
        end

        // R1 symbol count, R9 high byte zero
        pulses(1, 0, 10, 0, 0);
        grab(1, 0, 16'd10, "R1 R9");
        // R8 saturation at 255 and 31
        pulses(1, 0, 300, 0, 0);
        grab(1, 0, 16'd255, "R8");
        pulses(1, 3, 40, 0, 1);
        grab(1, 3, 16'd31, "R8 R9");
        // R2 transmit count crosses into the high byte
        pulses(0, 1, 300, 0, 0);
        grab(0, 1, 16'd300, "R2");
        // R3 R4 receive sorting on channel 2
        pulses(2, 2, 5, 0, 0);
        pulses(2, 2, 3, 1, 0);
        pulses(2, 2, 2, 0, 1);
        pulses(2, 2, 1, 1, 1);
        grab(2, 2, 16'd5, "R3");
        grab(2, 3, 16'd3, "R4");
        // R7 event in the same cycle as clear
        pulses(0, 1, 4, 0, 0);
        cycle('0, 3'b001, '0, '0, '0, 1, 8'h06, 8'h02, "R7");
        cycle('0, '0, '0, '0, '0, 0, 8'h04, 8'h00, "R7");
        check("R7", rdata, 8'd4);
        grab(0, 1, 16'd1, "R7");
        // R6 invalid select values are ignored
        pulses(0, 0, 7, 0, 0);
        cycle('0, '0, '0, '0, '0, 1, 8'h06, 8'h00, "R6");
        cycle('0, '0, '0, '0, '0, 1, 8'h06, 8'h03, "R6");
        cycle('0, '0, '0, '0, '0, 1, 8'h06, 8'h11, "R6");
        cycle('0, '0, '0, '0, '0, 1, 8'h06, 8'h10, "R6");
        cycle('0, '0, '0, '0, '0, 0, 8'h04, 8'h00, "R6");
        check("R6", rdata, 8'd1);
        grab(0, 0, 16'd7, "R6");
        // R10 channel independence and unmapped reads
        pulses(0, 1, 9, 0, 0);
        grab(1, 1, 16'd0, "R10");
        cycle('0, '0, '0, '0, '0, 0, 8'h36, 8'h00, "R10");
        check("R10", rdata, 8'h00);
        grab(0, 1, 16'd9, "R10");

        // constrained random traffic with model-checked reads
        for (int j = 0; j < 4000; j++) begin
            logic [7:0] a, d;
            logic w;
            int r = $urandom_range(0, 9);
            a = 8'($urandom_range(0, 3) * 16 + $urandom_range(3, 7));
            w = (r < 2);
            if (w) a[3:0] = 4'h6;
            case ($urandom_range(0, 5))
                0: d = 8'h00;
                1: d = 8'($urandom);
                default: d = 8'(1 << $urandom_range(0, 3));
            endcase
            cycle(NCH'($urandom), NCH'($urandom), NCH'($urandom),
                  NCH'($urandom) & NCH'($urandom), NCH'($urandom) & NCH'($urandom),
                  w, a, d, "R5 R7 R10");
        end
        for (int c = 0; c < NCH; c++)
            for (int q = 0; q < 4; q++)
                grab(c, q, 16'(mcnt[c][q]), "R5");
        idle_n(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule